// File: doc/BRIEF.md
# Audio Codec Mixer Register File

This block is the mixer control bank of an audio codec. A host reaches it through a plain indexed port. The port has a 7-bit register index, 16-bit write data, a write strobe, a read strobe and 16-bit read data. The bank holds four registers:

- A read-only capability word at index 0x00.
- A stereo master volume register at 0x02.
- A stereo line-level output volume register at 0x04.
- A mono output volume register at 0x06.

Every volume register carries a mute flag and one or two 5-bit attenuation codes. Each code step is 1.5 dB.

Any write to index 0x00 is a soft reset: the bank goes back to its defaults and the data is discarded. A volume write that sets the bit just above a 5-bit field saturates that field to its maximum code. Reserved bits, odd indices and unimplemented indices read back as zero.

The stored mute flags and attenuation codes leave the block as parallel outputs, so the analog gain stages can follow them directly. Each code is also given as an attenuation in half-dB units (code × 3).

Top module: `mixer_regfile`

## Requirements
- R1: A read of index 0x00 returns 0x5800, and no write ever changes that value.
- R2: Any write to index 0x00 returns every volume register to 0x8000 on the next clock edge, whatever the write data.
- R3: While rst_n is low at a rising clock edge, every volume register is loaded with 0x8000 (mute set, all codes zero), and rdata is cleared.
- R4: In the master (0x02) and line (0x04) registers, bit 15 is the mute flag (1 = muted), bits 12:8 are the left code and bits 4:0 are the right code. Bits 14:13 and 7:5 are never stored and read as 0.
- R5: In the mono register (0x06), bit 15 is the mute flag and bits 4:0 are the code. Bits 14:5 are never stored and read as 0.
- R6: A volume write with bit 13 set stores 5'h1F in the left field, and one with bit 5 set stores 5'h1F in the right or mono field, regardless of the field's own five bits.
- R7: A write to an odd index changes nothing, and a read of an odd index returns 0x0000.
- R8: A read of an even index other than 0x00–0x06 returns 0x0000, and a write to such an index changes nothing.
- R9: rdata shows the addressed register on the clock edge that samples rd_en high, and it holds its value until the next read.
- R10: The mute and code outputs follow the stored fields one edge after the write. Each half-dB output equals its code × 3, so 5'h1F gives 93.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idx | input | 7 | Register index |
| wdata | input | 16 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rdata | output | 16 | Registered read data |
| master_mute | output | 1 | Master mute flag |
| master_left_att | output | 5 | Master left attenuation code |
| master_right_att | output | 5 | Master right attenuation code |
| line_mute | output | 1 | Line output mute flag |
| line_left_att | output | 5 | Line output left attenuation code |
| line_right_att | output | 5 | Line output right attenuation code |
| mono_mute | output | 1 | Mono output mute flag |
| mono_att | output | 5 | Mono output attenuation code |
| master_left_hdb | output | 7 | Master left attenuation in 0.5 dB units |
| master_right_hdb | output | 7 | Master right attenuation in 0.5 dB units |
| line_left_hdb | output | 7 | Line left attenuation in 0.5 dB units |
| line_right_hdb | output | 7 | Line right attenuation in 0.5 dB units |
| mono_hdb | output | 7 | Mono attenuation in 0.5 dB units |

## Verification
Read data is due one edge after the edge that samples rd_en. The scoreboard records each read as pending at that edge and compares rdata on the following falling edge. Field outputs and half-dB values are due one edge after a write, or after a low rst_n. The bench checks them on the falling edge that follows the write strobe, once the write task has returned. Hold behaviour is checked by idling several cycles after a read and sampling rdata again on a falling edge. For writes that must have no effect, the bench reads the bank back, or samples the field outputs, before the next write.

// File: rtl/mixer_pkg.sv
// Shared constants, register indices and the field saturation rule for the
// codec mixer register bank. Assumes a 16-bit register width and 5-bit codes.
package mixer_pkg;
    localparam int IDX_W   = 7;
    localparam int DATA_W  = 16;
    localparam int FIELD_W = 5;
    localparam int HDB_W   = 7;

    localparam logic [IDX_W-1:0] IDX_CAPS   = 7'h00;
    localparam logic [IDX_W-1:0] IDX_MASTER = 7'h02;
    localparam logic [IDX_W-1:0] IDX_LINE   = 7'h04;
    localparam logic [IDX_W-1:0] IDX_MONO   = 7'h06;

    localparam logic [DATA_W-1:0] CAPS_WORD   = 16'h5800;
    localparam int                MUTE_BIT    = 15;
    localparam int                LEFT_LSB    = 8;
    localparam int                RIGHT_LSB   = 0;

    // Map a 6-bit raw write slice onto a 5-bit code; the top bit saturates.
    function automatic logic [FIELD_W-1:0] sat_code(input logic [FIELD_W:0] raw);
        return raw[FIELD_W] ? {FIELD_W{1'b1}} : raw[FIELD_W-1:0];
    endfunction
endpackage

// File: rtl/mixer_vol_reg.sv
// One volume register: mute flag plus one (mono) or two (stereo) saturating
// 5-bit attenuation codes. Assumes wr is already qualified by index decode and
// that clear (soft reset) has priority over a write in the same cycle.
module mixer_vol_reg
    import mixer_pkg::*;
#(
    parameter bit STEREO = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                wr,
    input  logic [DATA_W-1:0]   wdata,
    output logic                mute,
    output logic [FIELD_W-1:0]  left,
    output logic [FIELD_W-1:0]  right,
    output logic [DATA_W-1:0]   view
);
    logic unused_wdata;
    assign unused_wdata = ^wdata;

    // Mute flag: default muted, loaded from bit 15 on a write.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            mute <= 1'b1;
        else if (wr)
            mute <= wdata[MUTE_BIT];
    end

    // Right (or mono) code: saturates when the bit above the field is set.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            right <= '0;
        else if (wr)
            right <= sat_code(wdata[RIGHT_LSB+FIELD_W:RIGHT_LSB]);
    end

    generate
        if (STEREO) begin : g_stereo
            // Left code: stored only in stereo registers.
            always_ff @(posedge clk) begin
                if (!rst_n || clear)
                    left <= '0;
                else if (wr)
                    left <= sat_code(wdata[LEFT_LSB+FIELD_W:LEFT_LSB]);
            end
            // Read view with reserved bits forced to zero.
            always_comb view = {mute, 2'b00, left, 3'b000, right};
        end else begin : g_mono
            assign left = '0;
            // Read view: only mute and the single code are visible.
            always_comb view = {mute, 10'b0, right};
        end
    endgenerate
endmodule

// File: rtl/mixer_att_decode.sv
// Converts a 5-bit attenuation code (1.5 dB per step) into half-dB units.
// Purely combinational; assumes OUT_W can hold the largest code times three.
module mixer_att_decode
    import mixer_pkg::*;
#(
    parameter int OUT_W = HDB_W
) (
    input  logic [FIELD_W-1:0] code,
    output logic [OUT_W-1:0]   hdb
);
    localparam int PAD = OUT_W - FIELD_W;

    // code * 3 as a shift-and-add.
    always_comb hdb = {{(PAD-1){1'b0}}, code, 1'b0} + {{PAD{1'b0}}, code};
endmodule

// File: rtl/mixer_rd_port.sv
// Registered read port: selects the addressed register on a read strobe and
// holds it until the next one. Odd and unimplemented indices select zero.
module mixer_rd_port
    import mixer_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [IDX_W-1:0]   idx,
    input  logic [DATA_W-1:0]  master_view,
    input  logic [DATA_W-1:0]  line_view,
    input  logic [DATA_W-1:0]  mono_view,
    output logic [DATA_W-1:0]  rdata
);
    logic [DATA_W-1:0] sel;

    // Index decode for reads; any index not listed reads as zero.
    always_comb begin
        case (idx)
            IDX_CAPS:   sel = CAPS_WORD;
            IDX_MASTER: sel = master_view;
            IDX_LINE:   sel = line_view;
            IDX_MONO:   sel = mono_view;
            default:    sel = '0;
        endcase
    end

    // Capture the selection on a read strobe; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= sel;
    end
endmodule

// File: rtl/mixer_regfile.sv
// Top of the codec mixer register bank. Decodes writes, drives the soft reset
// from index 0x00, instances the three volume registers and the read port, and
// exposes codes, mute flags and half-dB values. Assumes one access per cycle.
module mixer_regfile
    import mixer_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [6:0]          idx,
    input  logic [15:0]         wdata,
    input  logic                wr_en,
    input  logic                rd_en,
    output logic [15:0]         rdata,
    output logic                master_mute,
    output logic [4:0]          master_left_att,
    output logic [4:0]          master_right_att,
    output logic                line_mute,
    output logic [4:0]          line_left_att,
    output logic [4:0]          line_right_att,
    output logic                mono_mute,
    output logic [4:0]          mono_att,
    output logic [6:0]          master_left_hdb,
    output logic [6:0]          master_right_hdb,
    output logic [6:0]          line_left_hdb,
    output logic [6:0]          line_right_hdb,
    output logic [6:0]          mono_hdb
);
    localparam int NVOL = 3;
    localparam logic [IDX_W-1:0] VOL_IDX [NVOL] = '{IDX_MASTER, IDX_LINE, IDX_MONO};

    logic                soft_clr;
    logic [NVOL-1:0]     vol_wr;
    logic [NVOL-1:0]     v_mute;
    logic [FIELD_W-1:0]  v_left  [NVOL];
    logic [FIELD_W-1:0]  v_right [NVOL];
    logic [DATA_W-1:0]   v_view  [NVOL];
    logic [FIELD_W-1:0]  codes   [5];
    logic [HDB_W-1:0]    hdbs    [5];

    // Soft reset: any write to the capability index.
    always_comb soft_clr = wr_en && (idx == IDX_CAPS);

    generate
        for (genvar i = 0; i < NVOL; i++) begin : g_vol
            // Per-register write decode.
            always_comb vol_wr[i] = wr_en && (idx == VOL_IDX[i]);

            mixer_vol_reg #(.STEREO(i != NVOL-1)) u_reg (
                .clk   (clk),
                .rst_n (rst_n),
                .clear (soft_clr),
                .wr    (vol_wr[i]),
                .wdata (wdata),
                .mute  (v_mute[i]),
                .left  (v_left[i]),
                .right (v_right[i]),
                .view  (v_view[i])
            );
        end
    endgenerate

    logic unused_mono_left;
    assign unused_mono_left = ^v_left[NVOL-1];

    // Route stored fields to the parallel outputs.
    always_comb begin
        master_mute      = v_mute[0];
        master_left_att  = v_left[0];
        master_right_att = v_right[0];
        line_mute        = v_mute[1];
        line_left_att    = v_left[1];
        line_right_att   = v_right[1];
        mono_mute        = v_mute[2];
        mono_att         = v_right[2];
        codes[0] = v_left[0];
        codes[1] = v_right[0];
        codes[2] = v_left[1];
        codes[3] = v_right[1];
        codes[4] = v_right[2];
    end

    generate
        for (genvar j = 0; j < 5; j++) begin : g_dec
            mixer_att_decode #(.OUT_W(HDB_W)) u_dec (
                .code (codes[j]),
                .hdb  (hdbs[j])
            );
        end
    endgenerate

    // Half-dB outputs.
    always_comb begin
        master_left_hdb  = hdbs[0];
        master_right_hdb = hdbs[1];
        line_left_hdb    = hdbs[2];
        line_right_hdb   = hdbs[3];
        mono_hdb         = hdbs[4];
    end

    mixer_rd_port u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en),
        .idx         (idx),
        .master_view (v_view[0]),
        .line_view   (v_view[1]),
        .mono_view   (v_view[2]),
        .rdata       (rdata)
    );
endmodule

// File: rtl/mixer_regfile_chk.sv
// Property checker for mixer_regfile, bound to every instance of the top.
// Observes ports only; assumes one access per cycle.
module mixer_regfile_chk (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [6:0]  idx,
    input  logic [15:0] wdata,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [15:0] rdata,
    input  logic        master_mute,
    input  logic [4:0]  master_left_att,
    input  logic [4:0]  master_right_att,
    input  logic        line_mute,
    input  logic [4:0]  line_left_att,
    input  logic [4:0]  line_right_att,
    input  logic        mono_mute,
    input  logic [4:0]  mono_att,
    input  logic [6:0]  master_left_hdb,
    input  logic [6:0]  master_right_hdb,
    input  logic [6:0]  line_left_hdb,
    input  logic [6:0]  line_right_hdb,
    input  logic [6:0]  mono_hdb
);
    a_r1_caps_word: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && idx == 7'h00) |=> rdata == 16'h5800);

    a_r2_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == 7'h00) |=> (master_mute && line_mute && mono_mute &&
         master_left_att == 5'd0 && master_right_att == 5'd0 &&
         line_left_att == 5'd0 && line_right_att == 5'd0 && mono_att == 5'd0));

    a_r6_left_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == 7'h02 && wdata[13]) |=> master_left_att == 5'h1F);

    a_r6_mono_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == 7'h06 && wdata[5]) |=> mono_att == 5'h1F);

    a_r7_odd_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && idx[0]) |=> rdata == 16'h0000);

    a_r7_odd_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx[0]) |=> $stable({master_mute, master_left_att, master_right_att,
                                      line_mute, line_left_att, line_right_att,
                                      mono_mute, mono_att}));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R10: half-dB outputs track code * 3 (separate decode logic).
    always_comb begin
        if (rst_n) begin
            a_r10_hdb_scale: assert (master_left_hdb == 7'(master_left_att) * 7'd3 &&
                                     master_right_hdb == 7'(master_right_att) * 7'd3 &&
                                     line_left_hdb == 7'(line_left_att) * 7'd3 &&
                                     line_right_hdb == 7'(line_right_att) * 7'd3 &&
                                     mono_hdb == 7'(mono_att) * 7'd3);
        end
    end
endmodule

bind mixer_regfile mixer_regfile_chk u_chk (.*);

// File: tb/mixer_regfile_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected data, a monitor compares rdata
// one edge later; field outputs are checked directly after each write.
module mixer_regfile_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  idx = '0;
    logic [15:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] rdata;
    logic        master_mute, line_mute, mono_mute;
    logic [4:0]  master_left_att, master_right_att, line_left_att, line_right_att, mono_att;
    logic [6:0]  master_left_hdb, master_right_hdb, line_left_hdb, line_right_hdb, mono_hdb;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    mixer_regfile u_mixer_regfile (.*);

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [6:0] i, input logic [15:0] d);
        @(negedge clk);
        idx = i; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [6:0] i, input logic [15:0] exp, input string req);
        @(negedge clk);
        idx = i; rd_en = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Monitor: a read sampled at an edge is compared on the next falling edge.
    initial begin
        forever begin
            logic pend;
            @(posedge clk);
            pend = rd_en;
            @(negedge clk);
            if (pend) begin
                if (exp_q.size() == 0) begin
                    check("R9 unexpected read", rdata, 16'hxxxx);
                end else begin
                    check(tag_q.pop_front(), rdata, exp_q.pop_front());
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R3 reset state
        check("R3 rdata after reset", rdata, 16'h0000);
        check("R3 mute flags", {13'd0, master_mute, line_mute, mono_mute}, 16'h0007);
        do_read(7'h00, 16'h5800, "R1 caps word");
        do_read(7'h02, 16'h8000, "R3 master default");
        do_read(7'h04, 16'h8000, "R3 line default");
        do_read(7'h06, 16'h8000, "R3 mono default");

        // R6 saturation on both stereo fields
        do_write(7'h02, 16'h7FFF);
        check("R6 master left sat", {11'd0, master_left_att}, 16'h001F);
        do_read(7'h02, 16'h1F1F, "R6 master readback");
        // R4 layout and R10 decode
        do_write(7'h02, 16'h8A05);
        check("R4 master left", {11'd0, master_left_att}, 16'h000A);
        check("R10 master left hdb", {9'd0, master_left_hdb}, 16'd30);
        check("R10 master right hdb", {9'd0, master_right_hdb}, 16'd15);
        do_read(7'h02, 16'h8A05, "R4 master readback");
        do_write(7'h04, 16'h40C3);
        do_read(7'h04, 16'h0003, "R4 line reserved bits");
        check("R10 line mute cleared", {15'd0, line_mute}, 16'h0000);
        // R5 mono layout, R6 mono saturation
        do_write(7'h06, 16'hFFD6);
        do_read(7'h06, 16'h8016, "R5 mono reserved bits");
        do_write(7'h06, 16'h0029);
        check("R6 mono sat", {11'd0, mono_att}, 16'h001F);
        check("R10 mono hdb", {9'd0, mono_hdb}, 16'd93);
        do_read(7'h06, 16'h001F, "R6 mono readback");

        // R7 odd index
        do_write(7'h03, 16'h1234);
        check("R7 odd write ignored", {11'd0, master_left_att}, 16'h000A);
        do_read(7'h03, 16'h0000, "R7 odd read");
        do_read(7'h01, 16'h0000, "R7 odd read 01");
        // R8 unimplemented even
        do_write(7'h08, 16'h0000);
        check("R8 write ignored", {15'd0, master_mute}, 16'h0001);
        do_read(7'h08, 16'h0000, "R8 read 08");
        do_read(7'h7E, 16'h0000, "R8 read 7E");
        do_read(7'h02, 16'h8A05, "R8 master unchanged");

        // R9 hold
        do_read(7'h00, 16'h5800, "R9 read before idle");
        repeat (5) @(negedge clk);
        check("R9 rdata held", rdata, 16'h5800);

        // R2 soft reset, R1 caps unchanged by write
        do_write(7'h00, 16'h1234);
        check("R2 mono mute set", {15'd0, mono_mute}, 16'h0001);
        do_read(7'h00, 16'h5800, "R1 caps after write");
        do_read(7'h02, 16'h8000, "R2 master default");
        do_read(7'h04, 16'h8000, "R2 line default");
        do_read(7'h06, 16'h8000, "R2 mono default");

        // R3 reset pin mid-run
        do_write(7'h04, 16'h0C0C);
        do_read(7'h04, 16'h0C0C, "R4 line set");
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R3 rdata cleared", rdata, 16'h0000);
        check("R3 line left cleared", {11'd0, line_left_att}, 16'h0000);
        do_read(7'h04, 16'h8000, "R3 line after reset");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R9 pending reads: actual %0d expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule